// File: doc/BRIEF.md
# Sized Integer Unit with Condition Codes

This block performs increment, arithmetic negate and signed multiply on byte, word or longword operands, where a longword is `XLEN` bits, a word half of that and a byte a quarter. A request is presented with `in_valid`, an 8-bit opcode, a 2-bit size code and up to three operands; one clock later the unit presents the result, truncated to the selected size and zero-filled above it, together with negative, zero, overflow and carry flags and an overflow exception indication.

Multiply comes in two forms that share one datapath: the two-operand form multiplies the running product input `in_prod` by the multiplier `in_src`, and the three-operand form multiplies `in_muld` by `in_src`. The carry flag means something different per operation: carry out of the top bit for increment, a nonzero result for negate, and always clear for multiply.

The output side is a two-state controller. `ST_IDLE` means no result is presented; `ST_VALID` means the output registers hold the result of the request accepted at the previous edge. Transitions: `ST_IDLE -> ST_VALID` on `in_valid`; `ST_VALID -> ST_VALID` on `in_valid` (back-to-back requests); `ST_VALID -> ST_IDLE` when `in_valid` is low; `ST_IDLE -> ST_IDLE` otherwise. Reset enters `ST_IDLE`.

Top module: `int_cc_unit`

## Requirements
- R1: A request accepted with `in_valid` high at a rising edge produces its outputs at that edge; `out_valid` is high in the following cycle exactly when `in_valid` was high at that edge, and back-to-back requests give one result per cycle.
- R2: Size code 0 selects `XLEN/4` bits, 1 selects `XLEN/2` bits, 2 selects `XLEN` bits; operand bits above the selected width are ignored and result bits above it are zero.
- R3: Opcode 0x96 (increment) gives `in_src + 1` truncated to the size; C is the carry out of the selected top bit and V is set exactly when the source is the largest positive value of that size.
- R4: Opcode 0x8E (negate) gives the two's complement negation of `in_src`; V is set exactly when the source is the most negative value of that size, and C is set exactly when the result is nonzero.
- R5: Opcode 0x84 (two-operand multiply) gives the low bits of the signed product `in_prod * in_src`; V is set when the full signed product does not fit in the selected size, C is always clear, and `in_muld` has no effect.
- R6: Opcode 0x85 (three-operand multiply) gives the signed product `in_muld * in_src` with the same flag rules as R5, and `in_prod` has no effect.
- R7: For every legal request N equals the top bit of the sized result and Z is set exactly when the sized result is zero.
- R8: `out_ovf_exc` is high exactly when V is high in a presented result.
- R9: Any other opcode, or size code 3, sets `out_bad_op` and forces the result, all four flags and the exception to zero.
- R10: After reset `out_valid`, `out_result`, all flags, `out_ovf_exc` and `out_bad_op` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_opcode | input | 8 | Operation code (0x96, 0x8E, 0x84, 0x85) |
| in_size | input | 2 | Operand size code (0 quarter, 1 half, 2 full width) |
| in_src | input | XLEN | Increment/negate source, multiplier |
| in_muld | input | XLEN | Multiplicand for the three-operand multiply |
| in_prod | input | XLEN | Running product for the two-operand multiply |
| out_valid | output | 1 | Result presented this cycle |
| out_result | output | XLEN | Sized result, zero above the selected width |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |
| out_ovf_exc | output | 1 | Integer overflow exception indication |
| out_bad_op | output | 1 | Unrecognised opcode or size code |

## Verification
The bench builds the unit with `XLEN = 8`, so the three sizes are 2, 4 and 8 bits wide. At that width every increment and negate source is swept at every size, including the extreme positive and negative values that drive overflow and carry, and multiply covers all 256 multipliers against sixteen multiplicands spread over the whole signed range, which reaches both product overflow directions and the truncation of junk bits above each size. The unused multiply operand is loaded with changing values in both forms, and bad opcodes and size code 3 are mixed into continuous traffic.

// File: rtl/iu_pkg.sv
package iu_pkg;

    typedef enum logic [2:0] {
        OP_INC,
        OP_NEG,
        OP_MUL2,
        OP_MUL3,
        OP_BAD
    } iu_op_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_VALID
    } iu_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } iu_cc_t;

    localparam logic [7:0] OPC_INC  = 8'h96;
    localparam logic [7:0] OPC_NEG  = 8'h8E;
    localparam logic [7:0] OPC_MUL2 = 8'h84;
    localparam logic [7:0] OPC_MUL3 = 8'h85;

    localparam int NUM_SIZES = 3;

endpackage

// File: rtl/iu_decode.sv
module iu_decode
    import iu_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [1:0] size_code,
    output iu_op_e     op
);

    iu_op_e op_raw;

    always_comb begin
        unique case (opcode)
            OPC_INC:  op_raw = OP_INC;
            OPC_NEG:  op_raw = OP_NEG;
            OPC_MUL2: op_raw = OP_MUL2;
            OPC_MUL3: op_raw = OP_MUL3;
            default:  op_raw = OP_BAD;
        endcase
    end

    // size code 3 has no width; treat the whole request as malformed
    assign op = (size_code == 2'd3) ? OP_BAD : op_raw;

endmodule

// File: rtl/iu_lane.sv
module iu_lane
    import iu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int W    = 8
) (
    input  iu_op_e          op,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] mcand,
    output logic [XLEN-1:0] res,
    output iu_cc_t          cc
);

    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0]          a_w;
    logic [W-1:0]          m_w;
    logic [W:0]            inc_sum;
    logic [W-1:0]          neg_val;
    logic signed [2*W-1:0] ext_a;
    logic signed [2*W-1:0] ext_m;
    logic signed [2*W-1:0] full_prod;
    logic                  mul_ovf;
    logic [W-1:0]          r_w;
    logic                  v_w;
    logic                  c_w;

    assign a_w = src[W-1:0];
    assign m_w = mcand[W-1:0];

    assign inc_sum = {1'b0, a_w} + {{W{1'b0}}, 1'b1};
    assign neg_val = {W{1'b0}} - a_w;

    assign ext_a     = {{W{a_w[W-1]}}, a_w};
    assign ext_m     = {{W{m_w[W-1]}}, m_w};
    assign full_prod = ext_a * ext_m;
    assign mul_ovf   = (full_prod[2*W-1:W] != {W{full_prod[W-1]}});

    always_comb begin
        unique case (op)
            OP_INC: begin
                r_w = inc_sum[W-1:0];
                v_w = (a_w == MAX_POS);
                c_w = inc_sum[W];
            end
            OP_NEG: begin
                r_w = neg_val;
                v_w = (a_w == MIN_NEG);
                c_w = (neg_val != {W{1'b0}});
            end
            OP_MUL2, OP_MUL3: begin
                r_w = full_prod[W-1:0];
                v_w = mul_ovf;
                c_w = 1'b0;
            end
            default: begin
                r_w = {W{1'b0}};
                v_w = 1'b0;
                c_w = 1'b0;
            end
        endcase
    end

    assign res  = XLEN'(r_w);
    assign cc.n = r_w[W-1];
    assign cc.z = (r_w == {W{1'b0}});
    assign cc.v = v_w;
    assign cc.c = c_w;

endmodule

// File: rtl/int_cc_unit.sv
module int_cc_unit
    import iu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [7:0]      in_opcode,
    input  logic [1:0]      in_size,
    input  logic [XLEN-1:0] in_src,
    input  logic [XLEN-1:0] in_muld,
    input  logic [XLEN-1:0] in_prod,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result,
    output logic            out_n,
    output logic            out_z,
    output logic            out_v,
    output logic            out_c,
    output logic            out_ovf_exc,
    output logic            out_bad_op
);

    iu_op_e          op;
    logic [XLEN-1:0] mcand;
    logic [XLEN-1:0] lane_res [NUM_SIZES];
    iu_cc_t          lane_cc  [NUM_SIZES];
    logic [XLEN-1:0] sel_res;
    iu_cc_t          sel_cc;
    logic            sel_bad;

    iu_state_e       state_q, state_d;
    logic [XLEN-1:0] res_q;
    iu_cc_t          cc_q;
    logic            bad_q;

    iu_decode u_dec (
        .opcode    (in_opcode),
        .size_code (in_size),
        .op        (op)
    );

    // two-operand form multiplies the running product, three-operand the multiplicand
    assign mcand = (op == OP_MUL3) ? in_muld : in_prod;

    for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_lane
        localparam int LW = XLEN >> (NUM_SIZES - 1 - gi);
        iu_lane #(
            .XLEN (XLEN),
            .W    (LW)
        ) u_lane (
            .op    (op),
            .src   (in_src),
            .mcand (mcand),
            .res   (lane_res[gi]),
            .cc    (lane_cc[gi])
        );
    end

    always_comb begin
        sel_bad = (op == OP_BAD);
        unique case (in_size)
            2'd0:    begin sel_res = lane_res[0]; sel_cc = lane_cc[0]; end
            2'd1:    begin sel_res = lane_res[1]; sel_cc = lane_cc[1]; end
            2'd2:    begin sel_res = lane_res[2]; sel_cc = lane_cc[2]; end
            default: begin sel_res = '0;          sel_cc = '0;         end
        endcase
        if (sel_bad) begin
            sel_res = '0;
            sel_cc  = '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = in_valid ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            cc_q  <= '0;
            bad_q <= 1'b0;
        end else if (in_valid) begin
            res_q <= sel_res;
            cc_q  <= sel_cc;
            bad_q <= sel_bad;
        end
    end

    assign out_valid   = (state_q == ST_VALID);
    assign out_result  = res_q;
    assign out_n       = cc_q.n;
    assign out_z       = cc_q.z;
    assign out_v       = cc_q.v;
    assign out_c       = cc_q.c;
    assign out_ovf_exc = cc_q.v;
    assign out_bad_op  = bad_q;

endmodule

// File: rtl/iu_checker.sv
module iu_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [7:0]      in_opcode,
    input logic [1:0]      in_size,
    input logic            out_valid,
    input logic [XLEN-1:0] out_result,
    input logic            out_n,
    input logic            out_z,
    input logic            out_v,
    input logic            out_c,
    input logic            out_ovf_exc,
    input logic            out_bad_op
);

    logic legal_size;
    logic is_mul;
    logic is_neg;

    assign legal_size = (in_size != 2'd3);
    assign is_mul     = legal_size && ((in_opcode == 8'h84) || (in_opcode == 8'h85));
    assign is_neg     = legal_size && (in_opcode == 8'h8E);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1

    AST_QUARTER_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'd0) |=> ((out_result >> (XLEN/4)) == '0)); // R2

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'd1) |=> ((out_result >> (XLEN/2)) == '0)); // R2

    AST_NEG_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_neg) |=> (out_c == (out_result != '0))); // R4

    AST_MUL_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_mul) |=> !out_c); // R5

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_bad_op) |-> (out_z == (out_result == '0))); // R7

    AST_EXC_IS_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ovf_exc == out_v)); // R8

    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_bad_op |-> (out_result == '0 && !out_n && !out_z && !out_v && !out_c && !out_ovf_exc)); // R9

endmodule

bind int_cc_unit iu_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_opcode   (in_opcode),
    .in_size     (in_size),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_n       (out_n),
    .out_z       (out_z),
    .out_v       (out_v),
    .out_c       (out_c),
    .out_ovf_exc (out_ovf_exc),
    .out_bad_op  (out_bad_op)
);

// File: tb/sim_int_cc_unit.sv
module sim_int_cc_unit;

    localparam int XLEN = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int WATCHDOG_CYCLES = 200000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [7:0]      in_opcode = 8'h00;
    logic [1:0]      in_size = 2'd0;
    logic [XLEN-1:0] in_src = '0;
    logic [XLEN-1:0] in_muld = '0;
    logic [XLEN-1:0] in_prod = '0;
    logic            out_valid;
    logic [XLEN-1:0] out_result;
    logic            out_n, out_z, out_v, out_c, out_ovf_exc, out_bad_op;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_cc_unit #(.XLEN(XLEN)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_opcode   (in_opcode),
        .in_size     (in_size),
        .in_src      (in_src),
        .in_muld     (in_muld),
        .in_prod     (in_prod),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_n       (out_n),
        .out_z       (out_z),
        .out_v       (out_v),
        .out_c       (out_c),
        .out_ovf_exc (out_ovf_exc),
        .out_bad_op  (out_bad_op)
    );

    // reference model: opsel 0 increment, 1 negate, 2 multiply
    task automatic model(input int opsel, input int sz, input int a, input int b,
                         output int r, output bit n, output bit z, output bit v, output bit c);
        int w    = XLEN >> (2 - sz);
        int mask = (1 << w) - 1;
        int half = 1 << (w - 1);
        int ua   = a & mask;
        int ub   = b & mask;
        int sa   = (ua >= half) ? ua - (1 << w) : ua;
        int sb   = (ub >= half) ? ub - (1 << w) : ub;
        int raw;
        case (opsel)
            0: begin
                raw = ua + 1;
                r = raw & mask;
                c = ((raw >> w) & 1) != 0;
                v = (sa == half - 1);
            end
            1: begin
                r = (-ua) & mask;
                v = (sa == -half);
                c = (r != 0);
            end
            default: begin
                raw = sa * sb;
                r = raw & mask;
                v = (raw < -half) || (raw > half - 1);
                c = 1'b0;
            end
        endcase
        n = ((r >> (w - 1)) & 1) != 0;
        z = (r == 0);
    endtask

    task automatic check_out(input string tag, input int er, input bit en, input bit ez,
                             input bit ev, input bit ec, input bit ebad);
        checks++;
        if (out_valid !== 1'b1 || out_result !== XLEN'(er) || out_n !== en || out_z !== ez ||
            out_v !== ev || out_c !== ec || out_ovf_exc !== ev || out_bad_op !== ebad) begin
            errors++;
            $display("FAIL %s: got valid=%b res=%h nzvc=%b%b%b%b exc=%b bad=%b, expected valid=1 res=%h nzvc=%b%b%b%b exc=%b bad=%b",
                     tag, out_valid, out_result, out_n, out_z, out_v, out_c, out_ovf_exc, out_bad_op,
                     XLEN'(er), en, ez, ev, ec, ev, ebad);
        end
    endtask

    task automatic drive(input logic [7:0] opc, input logic [1:0] sz, input logic [7:0] a,
                         input logic [7:0] md, input logic [7:0] pr);
        in_valid  = 1'b1;
        in_opcode = opc;
        in_size   = sz;
        in_src    = a;
        in_muld   = md;
        in_prod   = pr;
        @(negedge clk);
    endtask

    initial begin
        int r;
        bit n, z, v, c;

        repeat (3) @(negedge clk);
        // R10: reset state
        checks++;
        if (out_valid !== 0 || out_result !== '0 || out_n !== 0 || out_z !== 0 || out_v !== 0 ||
            out_c !== 0 || out_ovf_exc !== 0 || out_bad_op !== 0) begin
            errors++;
            $display("FAIL R10: got valid=%b res=%h flags=%b%b%b%b exc=%b bad=%b, expected all zero",
                     out_valid, out_result, out_n, out_z, out_v, out_c, out_ovf_exc, out_bad_op);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3, R7, R8, R2: increment sweep, all sources and sizes
        for (int sz = 0; sz < 3; sz++) begin
            for (int a = 0; a < 256; a++) begin
                drive(8'h96, 2'(sz), 8'(a), 8'(a * 7), 8'(a * 3));
                model(0, sz, a, 0, r, n, z, v, c);
                check_out("R3 increment", r, n, z, v, c, 1'b0);
            end
        end

        // R4, R7, R8, R2: negate sweep
        for (int sz = 0; sz < 3; sz++) begin
            for (int a = 0; a < 256; a++) begin
                drive(8'h8E, 2'(sz), 8'(a), 8'(a + 11), 8'(a * 5));
                model(1, sz, a, 0, r, n, z, v, c);
                check_out("R4 negate", r, n, z, v, c, 1'b0);
            end
        end

        // R5 two-operand multiply (muld holds junk), R6 three-operand (prod holds junk)
        for (int sz = 0; sz < 3; sz++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 16; k++) begin
                    model(2, sz, a, k * 17, r, n, z, v, c);
                    drive(8'h84, 2'(sz), 8'(a), 8'(a ^ (k * 29)), 8'(k * 17));
                    check_out("R5 multiply two-operand", r, n, z, v, c, 1'b0);
                    drive(8'h85, 2'(sz), 8'(a), 8'(k * 17), 8'(~a + k));
                    check_out("R6 multiply three-operand", r, n, z, v, c, 1'b0);
                end
            end
        end

        // R9: unknown opcodes and size code 3
        drive(8'h00, 2'd0, 8'h7F, 8'h01, 8'h01);
        check_out("R9 opcode 0x00", 0, 0, 0, 0, 0, 1'b1);
        drive(8'h97, 2'd2, 8'h7F, 8'h01, 8'h01);
        check_out("R9 opcode 0x97", 0, 0, 0, 0, 0, 1'b1);
        drive(8'h8F, 2'd1, 8'h80, 8'h01, 8'h01);
        check_out("R9 opcode 0x8F", 0, 0, 0, 0, 0, 1'b1);
        drive(8'h96, 2'd3, 8'h7F, 8'h01, 8'h01);
        check_out("R9 size code 3 increment", 0, 0, 0, 0, 0, 1'b1);
        drive(8'h84, 2'd3, 8'hFF, 8'h80, 8'h80);
        check_out("R9 size code 3 multiply", 0, 0, 0, 0, 0, 1'b1);
        // a legal request right after a bad one clears the bad indication
        drive(8'h96, 2'd2, 8'h7F, 8'h00, 8'h00);
        check_out("R9 recovery", 8'h80, 1, 0, 1, 0, 1'b0);

        // R1: out_valid drops one cycle after in_valid drops, result is held
        in_valid = 1'b0;
        in_opcode = 8'h8E;
        in_src = 8'h05;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_result !== 8'h80) begin
            errors++;
            $display("FAIL R1: got valid=%b res=%h, expected valid=0 res=80", out_valid, out_result);
        end
        @(negedge clk);
        drive(8'h8E, 2'd2, 8'h05, 8'h00, 8'h00);
        check_out("R1 restart after idle", 8'hFB, 1, 0, 0, 1, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no completion, expected finish within %0d cycles", WATCHDOG_CYCLES);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule